// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register Bank

This block holds the 32-bit software-visible control registers of a per-core interrupt controller. A requester presents a register index together with a write strobe and write data, a read strobe, or both. Every register applies its own write rule: some store the data unchanged, one keeps only a high byte, one forces its low bits to one, one ignores writes entirely, and a group of local-vector registers keeps two status bits that software cannot change. Read data is registered. Any access to an index that no register occupies raises an error strobe.

The bank also keeps a small internal state word with two flags. The first is a handshake flag for the error-status register. Each write to that register toggles the flag, and a read clears it. The second is a software-enable flag, which is loaded from bit 8 of every write to the spurious-vector register. The state word can be read at its own index, and that read has no side effects. If a write and a read arrive in the same cycle, the read returns the contents from before the write. The write's effect on the handshake flag then takes precedence over the read's clearing effect.

The asynchronous active-low reset is released through a two-stage synchronizer. The register contents therefore leave reset two clock edges after the reset input rises.

Top module: `lic_regbank`

## Requirements
- R1: After reset every register reads zero, except the destination-format register at index 3, which reads 32'hFFFF_FFFF. The state word also reads zero.
- R2: A write to the logical-destination register at index 2 stores bits 31:24 of the write data and stores zero in bits 23:0.
- R3: A write to the destination-format register at index 3 stores the write data with bits 27:0 forced to one.
- R4: The version register at index 1 is read-only. Writes to it have no effect, and it always reads zero.
- R5: The six local-vector registers occupy indices 8 to 13. In each of them, bits 12 and 14 are read-only: a write keeps their stored values and takes every other bit from the write data.
- R6: A write to the spurious-vector register at index 4 stores the full write data. It copies write-data bit 8 into state bit 8, the enable flag, and leaves state bit 1 clear.
- R7: A read of the error-status register at index 5 returns its stored value and clears state bit 0, the handshake flag.
- R8: A write to the error-status register stores the full write data. It toggles state bit 0: the bit is cleared if it was set and set if it was clear.
- R9: An access to an unimplemented index (7, or 14 to 63) changes no register, raises err_o for exactly the cycle after the access, and, when it is a read, returns zero.
- R10: rvalid_o is high for exactly the one cycle after each cycle in which rd_en_i is high. rdata_o is valid in that same cycle.
- R11: The state word at index 6 reads as {23'b0, enable, 7'b0, handshake}. It is read-only, and reading it changes nothing.
- R12: The identifier register at index 0 stores and returns the full 32-bit write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| idx_i | input | 6 | Register index of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data; holds its value between reads |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| err_o | output | 1 | One-cycle strobe for an access to an unimplemented index |

## Verification
The bench sweeps every index under several data patterns, including all ones, and checks each read against an arithmetic model. Three kinds of faults are targeted in this sweep. A masking slip would leak low bits of the logical-destination register or drop the forced ones in the destination-format register. A write that reaches the version register, or reaches bits 12 and 14 of a local-vector register, would show up as ones in the read-back. A decode hole would let writes to unimplemented indices land in real registers, or would leave the error strobe silent.

The handshake flag is driven through write-write-read sequences. A design that set the flag on every write instead of toggling it, or that failed to clear it on a read, would show the wrong bit 0 in the state word. A state-word read with side effects would corrupt the next read. A final second reset confirms that the destination-format register returns to all ones while every other register returns to zero.

// File: rtl/lic_regbank_pkg.sv
package lic_regbank_pkg;

  localparam int LIC_DW       = 32;
  localparam int LIC_IDX_W    = 6;
  localparam int LIC_NUM_LVT  = 6;
  localparam int LIC_LVT_BASE = 8;

  // fixed register indices
  localparam int IX_ID    = 0;
  localparam int IX_VER   = 1;
  localparam int IX_LDEST = 2;
  localparam int IX_DFMT  = 3;
  localparam int IX_SPUR  = 4;
  localparam int IX_ESR   = 5;
  localparam int IX_STATE = 6;

  // write rules
  localparam logic [LIC_DW-1:0] LDEST_KEEP_DEF = 32'hFF00_0000;
  localparam logic [LIC_DW-1:0] DFMT_FORCE_DEF = 32'h0FFF_FFFF;
  localparam logic [LIC_DW-1:0] DFMT_RST_DEF   = 32'hFFFF_FFFF;
  localparam logic [LIC_DW-1:0] LVT_RO_DEF     = 32'h0000_5000;

  // internal state word bit positions
  localparam int ST_HS_BIT = 0;
  localparam int ST_EN_BIT = 8;

  typedef struct packed {
    logic id;
    logic ver;
    logic ldest;
    logic dfmt;
    logic spur;
    logic esr;
    logic state;
  } fix_sel_t;

endpackage

// File: rtl/lic_rst_sync.sv
module lic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/lic_regbank_decode.sv
module lic_regbank_decode
  import lic_regbank_pkg::*;
#(
  parameter int IDX_W    = LIC_IDX_W,
  parameter int NUM_LVT  = LIC_NUM_LVT,
  parameter int LVT_BASE = LIC_LVT_BASE
) (
  input  logic [IDX_W-1:0]   idx_i,
  output fix_sel_t           fix_sel_o,
  output logic [NUM_LVT-1:0] lvt_sel_o,
  output logic               hit_o
);

  always_comb begin
    fix_sel_o = '0;
    case (idx_i)
      IDX_W'(IX_ID):    fix_sel_o.id    = 1'b1;
      IDX_W'(IX_VER):   fix_sel_o.ver   = 1'b1;
      IDX_W'(IX_LDEST): fix_sel_o.ldest = 1'b1;
      IDX_W'(IX_DFMT):  fix_sel_o.dfmt  = 1'b1;
      IDX_W'(IX_SPUR):  fix_sel_o.spur  = 1'b1;
      IDX_W'(IX_ESR):   fix_sel_o.esr   = 1'b1;
      IDX_W'(IX_STATE): fix_sel_o.state = 1'b1;
      default: ;
    endcase
  end

  for (genvar k = 0; k < NUM_LVT; k++) begin : g_lvt_dec
    assign lvt_sel_o[k] = (idx_i == IDX_W'(LVT_BASE + k));
  end

  assign hit_o = (|fix_sel_o) | (|lvt_sel_o);

endmodule

// File: rtl/lic_regbank_wmask.sv
module lic_regbank_wmask
  import lic_regbank_pkg::*;
#(
  parameter int              DW         = LIC_DW,
  parameter int              NUM_LVT    = LIC_NUM_LVT,
  parameter logic [DW-1:0]   LDEST_KEEP = LDEST_KEEP_DEF,
  parameter logic [DW-1:0]   DFMT_FORCE = DFMT_FORCE_DEF,
  parameter logic [DW-1:0]   LVT_RO     = LVT_RO_DEF
) (
  input  logic [DW-1:0]              wdata_i,
  input  logic [NUM_LVT-1:0][DW-1:0] lvt_old_i,
  output logic [DW-1:0]              ldest_new_o,
  output logic [DW-1:0]              dfmt_new_o,
  output logic [NUM_LVT-1:0][DW-1:0] lvt_new_o
);

  assign ldest_new_o = wdata_i & LDEST_KEEP;
  assign dfmt_new_o  = wdata_i | DFMT_FORCE;

  for (genvar k = 0; k < NUM_LVT; k++) begin : g_lvt_mask
    assign lvt_new_o[k] = (wdata_i & ~LVT_RO) | (lvt_old_i[k] & LVT_RO);
  end

endmodule

// File: rtl/lic_regbank_flags.sv
module lic_regbank_flags
  import lic_regbank_pkg::*;
#(
  parameter int DW = LIC_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_spur_i,
  input  logic          wr_esr_i,
  input  logic          rd_esr_i,
  input  logic          en_bit_i,
  output logic [DW-1:0] state_o
);

  logic hs_q, hs_d, hs_ce;
  logic en_q, en_d, en_ce;

  always_comb begin
    hs_ce = wr_esr_i | rd_esr_i;
    en_ce = wr_spur_i;
    hs_d  = hs_q;
    en_d  = en_q;
    if (wr_esr_i)      hs_d = ~hs_q;
    else if (rd_esr_i) hs_d = 1'b0;
    if (wr_spur_i)     en_d = en_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      if (hs_ce) hs_q <= hs_d;
      if (en_ce) en_q <= en_d;
    end
  end

  always_comb begin
    state_o            = '0;
    state_o[ST_HS_BIT] = hs_q;
    state_o[ST_EN_BIT] = en_q;
  end

  // R8: an error-status write flips the handshake flag
  assert_esr_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_esr_i |=> (hs_q != $past(hs_q)));

  // R7: a read without a concurrent write clears the handshake flag
  assert_esr_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_esr_i && !wr_esr_i) |=> !hs_q);

  // R6: enable follows bit 8 of the spurious-vector write
  assert_spur_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spur_i |=> (en_q == $past(en_bit_i)));

endmodule

// File: rtl/lic_regbank.sv
module lic_regbank
  import lic_regbank_pkg::*;
#(
  parameter int            DW            = LIC_DW,
  parameter int            IDX_W         = LIC_IDX_W,
  parameter int            NUM_LVT       = LIC_NUM_LVT,
  parameter int            LVT_BASE      = LIC_LVT_BASE,
  parameter logic [DW-1:0] LDEST_KEEP    = LDEST_KEEP_DEF,
  parameter logic [DW-1:0] DFMT_FORCE    = DFMT_FORCE_DEF,
  parameter logic [DW-1:0] DFMT_RST      = DFMT_RST_DEF,
  parameter logic [DW-1:0] LVT_RO        = LVT_RO_DEF,
  parameter logic [DW-1:0] VERSION_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             err_o
);

  logic rst_n_int;

  lic_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  // ---------------- decode ----------------
  fix_sel_t           fix_sel;
  logic [NUM_LVT-1:0] lvt_sel;
  logic               hit;

  lic_regbank_decode #(
    .IDX_W    (IDX_W),
    .NUM_LVT  (NUM_LVT),
    .LVT_BASE (LVT_BASE)
  ) u_decode (
    .idx_i     (idx_i),
    .fix_sel_o (fix_sel),
    .lvt_sel_o (lvt_sel),
    .hit_o     (hit)
  );

  // ---------------- storage ----------------
  logic [DW-1:0]              id_q, ldest_q, dfmt_q, spur_q, esr_q;
  logic [NUM_LVT-1:0][DW-1:0] lvt_q;
  logic [DW-1:0]              ldest_new, dfmt_new;
  logic [NUM_LVT-1:0][DW-1:0] lvt_new;
  logic [DW-1:0]              state_word;

  lic_regbank_wmask #(
    .DW         (DW),
    .NUM_LVT    (NUM_LVT),
    .LDEST_KEEP (LDEST_KEEP),
    .DFMT_FORCE (DFMT_FORCE),
    .LVT_RO     (LVT_RO)
  ) u_wmask (
    .wdata_i     (wdata_i),
    .lvt_old_i   (lvt_q),
    .ldest_new_o (ldest_new),
    .dfmt_new_o  (dfmt_new),
    .lvt_new_o   (lvt_new)
  );

  logic id_ce, ldest_ce, dfmt_ce, spur_ce, esr_ce;
  logic [NUM_LVT-1:0] lvt_ce;

  always_comb begin
    id_ce    = wr_en_i & fix_sel.id;
    ldest_ce = wr_en_i & fix_sel.ldest;
    dfmt_ce  = wr_en_i & fix_sel.dfmt;
    spur_ce  = wr_en_i & fix_sel.spur;
    esr_ce   = wr_en_i & fix_sel.esr;
    lvt_ce   = {NUM_LVT{wr_en_i}} & lvt_sel;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      id_q    <= '0;
      ldest_q <= '0;
      dfmt_q  <= DFMT_RST;
      spur_q  <= '0;
      esr_q   <= '0;
    end else begin
      if (id_ce)    id_q    <= wdata_i;
      if (ldest_ce) ldest_q <= ldest_new;
      if (dfmt_ce)  dfmt_q  <= dfmt_new;
      if (spur_ce)  spur_q  <= wdata_i;
      if (esr_ce)   esr_q   <= wdata_i;
    end
  end

  for (genvar k = 0; k < NUM_LVT; k++) begin : g_lvt_reg
    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int)     lvt_q[k] <= '0;
      else if (lvt_ce[k]) lvt_q[k] <= lvt_new[k];
    end

    // R5: protected bits survive any write to this vector entry
    assert_lvt_ro_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
      lvt_ce[k] |=> ((lvt_q[k] & LVT_RO) == ($past(lvt_q[k]) & LVT_RO)));
  end

  // ---------------- internal flags ----------------
  lic_regbank_flags #(.DW(DW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_spur_i (spur_ce),
    .wr_esr_i  (esr_ce),
    .rd_esr_i  (rd_en_i & fix_sel.esr),
    .en_bit_i  (wdata_i[ST_EN_BIT]),
    .state_o   (state_word)
  );

  // ---------------- read path ----------------
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (fix_sel.id)    rd_mux = id_q;
    if (fix_sel.ver)   rd_mux = VERSION_VALUE;
    if (fix_sel.ldest) rd_mux = ldest_q;
    if (fix_sel.dfmt)  rd_mux = dfmt_q;
    if (fix_sel.spur)  rd_mux = spur_q;
    if (fix_sel.esr)   rd_mux = esr_q;
    if (fix_sel.state) rd_mux = state_word;
    for (int k = 0; k < NUM_LVT; k++) begin
      if (lvt_sel[k]) rd_mux = lvt_q[k];
    end
  end

  logic [DW-1:0] rdata_q, rdata_d;
  logic          rdata_ce;
  logic          rvalid_q, err_q, err_d;

  always_comb begin
    rdata_ce = rd_en_i;
    rdata_d  = rd_mux;
    err_d    = (rd_en_i | wr_en_i) & ~hit;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (rdata_ce) rdata_q <= rdata_d;
      rvalid_q <= rd_en_i;
      err_q    <= err_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;

  // ---------------- assertions ----------------
  // R2: only the kept byte survives a logical-destination write
  assert_ldest_mask_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    ldest_ce |=> (ldest_q == ($past(wdata_i) & LDEST_KEEP)));

  // R3: low field forced to ones on a destination-format write
  assert_dfmt_force_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    dfmt_ce |=> (dfmt_q == ($past(wdata_i) | DFMT_FORCE)));

  // R4: version read returns the fixed value regardless of earlier writes
  assert_version_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en_i && fix_sel.ver) |=> (rdata_o == VERSION_VALUE));

  // R9: unimplemented access flags an error and reads as zero
  assert_unimpl_err_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((rd_en_i || wr_en_i) && !hit) |=> (err_o && (!rvalid_o || rdata_o == '0)));

  // R9: an unimplemented write leaves the stored registers alone
  assert_unimpl_nochange_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en_i && !hit) |=> ($stable(id_q) && $stable(ldest_q) && $stable(dfmt_q) &&
                           $stable(spur_q) && $stable(esr_q) && $stable(lvt_q)));

  // R9: no error without an unimplemented access
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    !((rd_en_i || wr_en_i) && !hit) |=> !err_o);

  // R10: valid follows the read strobe by exactly one cycle
  assert_rvalid_timing_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_en_i |=> rvalid_o);
  assert_rvalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_en_i |=> !rvalid_o);

endmodule

// File: tb/lic_regbank_bench.sv
`timescale 1ns/1ps
module lic_regbank_bench;

  logic        clk;
  logic        rst_n;
  logic [5:0]  idx;
  logic        wr_en;
  logic [31:0] wdata;
  logic        rd_en;
  logic [31:0] rdata;
  logic        rvalid;
  logic        err;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  lic_regbank u_lic_regbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_i    (idx),
    .wr_en_i  (wr_en),
    .wdata_i  (wdata),
    .rd_en_i  (rd_en),
    .rdata_o  (rdata),
    .rvalid_o (rvalid),
    .err_o    (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] mdl [64];
  logic        m_hs, m_en;

  function automatic bit is_impl(input logic [5:0] ix);
    return (ix <= 6'd6) || (ix >= 6'd8 && ix <= 6'd13);
  endfunction

  function automatic string tag_of(input logic [5:0] ix);
    case (ix)
      6'd0: return "R12";
      6'd1: return "R4";
      6'd2: return "R2";
      6'd3: return "R3";
      6'd4: return "R6";
      6'd5: return "R8";
      6'd6: return "R11";
      default: return (ix >= 6'd8 && ix <= 6'd13) ? "R5" : "R9";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mdl[i] = 32'h0;
    mdl[3] = 32'hFFFF_FFFF;
    m_hs = 1'b0;
    m_en = 1'b0;
  endtask

  task automatic model_write(input logic [5:0] ix, input logic [31:0] d);
    case (ix)
      6'd0: mdl[0] = d;
      6'd2: mdl[2] = {d[31:24], 24'h0};
      6'd3: mdl[3] = {d[31:28], 28'hFFF_FFFF};
      6'd4: begin mdl[4] = d; m_en = d[8]; end
      6'd5: begin mdl[5] = d; m_hs = ~m_hs; end
      default: if (ix >= 6'd8 && ix <= 6'd13)
                 mdl[ix] = {d[31:15], mdl[ix][14], d[13], mdl[ix][12], d[11:0]};
    endcase
  endtask

  task automatic model_read(input logic [5:0] ix, output logic [31:0] v);
    if (!is_impl(ix))      v = 32'h0;
    else if (ix == 6'd6)   v = {23'h0, m_en, 7'h0, m_hs};
    else                   v = mdl[ix];
    if (ix == 6'd5) m_hs = 1'b0;
  endtask

  // ---------------- check helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [5:0] ix, input logic w, input logic r,
                        input logic [31:0] d);
    @(negedge clk);
    idx = ix; wr_en = w; rd_en = r; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] ix, input logic [31:0] d);
    access(ix, 1'b1, 1'b0, d);
    check(is_impl(ix) ? tag_of(ix) : "R9", {31'h0, err}, {31'h0, !is_impl(ix)});
    check("R10", {31'h0, rvalid}, 32'h0);
    model_write(ix, d);
  endtask

  task automatic do_read(input logic [5:0] ix, input string tag);
    logic [31:0] exp;
    access(ix, 1'b0, 1'b1, 32'h0);
    model_read(ix, exp);
    check(tag, rdata, exp);
    check("R10", {31'h0, rvalid}, 32'h1);
    check("R9", {31'h0, err}, {31'h0, !is_impl(ix)});
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] pats [4];

  initial begin
    idx = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; rst_n = 1'b0;
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_5B5A;
    pats[3] = 32'h1234_5678;
    apply_reset();

    // R1: reset contents of every index, no read yet so valid is low
    check("R10", {31'h0, rvalid}, 32'h0);
    check("R9", {31'h0, err}, 32'h0);
    for (int i = 0; i < 64; i++) do_read(6'(i), is_impl(6'(i)) ? "R1" : "R9");

    // write then read back every index under each pattern
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 64; i++) begin
        do_write(6'(i), pats[p] ^ (32'h0101_0101 * i));
        do_read(6'(i), tag_of(6'(i)));
      end
      // unimplemented writes above must not have disturbed real registers (R9)
      for (int i = 0; i < 14; i++) if (is_impl(6'(i))) do_read(6'(i), "R9");
    end

    // R8 toggle sequence, R7 read clear, R11 side-effect-free state reads
    do_write(6'd5, 32'h0000_00C3);
    do_read(6'd6, "R8");
    do_read(6'd6, "R11");
    do_write(6'd5, 32'h0000_0011);
    do_read(6'd6, "R8");
    do_write(6'd5, 32'h0000_0022);
    do_read(6'd6, "R8");
    do_read(6'd5, "R7");
    do_read(6'd6, "R7");
    do_read(6'd5, "R7");
    do_write(6'd5, 32'h0);
    do_read(6'd6, "R8");

    // R6 enable flag follows bit 8
    do_write(6'd4, 32'h0000_0100);
    do_read(6'd6, "R6");
    do_write(6'd4, 32'hFFFF_FEFF);
    do_read(6'd6, "R6");
    do_read(6'd4, "R6");

    // R1 again after a second reset
    apply_reset();
    for (int i = 0; i < 14; i++) do_read(6'(i), "R1");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule